// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block keeps an asynchronous DRAM alive without help from the rest of the memory subsystem. After reset it holds off for a power-up pause. It then runs a fixed burst of refresh cycles in which CAS falls before RAS, so the row address comes from the memory's own internal counter. After that burst it paces one such refresh per interval, so that 2048 of them fit inside every retention period.

The strobes are shared with the normal access controller. The sequencer raises a pin request and touches the strobes only while the controller returns a grant. The write strobe stays high through every refresh, so a refresh can never be taken as the entry into a test mode. Refreshes that fall due while the grant is withheld are remembered, up to a small cap, and are run back to back once the grant arrives.

A parameter selects between the standard 32 ms retention period and the 128 ms low-power period. An initialization flag tells the access controller when it may start serving requests.

Top module: `dref_seq`

## Requirements
- R1: While reset is held, and right after it, pin_req is 0, ras_n, cas_n and we_n are 1, and init_done and ref_done are 0.
- R2: After reset is released, pin_req stays low for the power-up pause of PAUSE_US times CLK_MHZ cycles (25000 at the defaults).
- R3: After the pause, exactly INIT_REFRESHES (8) refreshes run back to back, one every 1 + CSR + RAS + RP clock cycles (16 at the defaults). init_done rises in the cycle after the eighth ref_done and then stays high.
- R4: In every refresh, cas_n goes low for exactly ceil(10 ns) clock cycles (2) before ras_n falls. cas_n stays low for the whole RAS-low time, and both strobes rise on the same edge.
- R5: we_n is high at every falling edge of ras_n and in the cycle before it, so no refresh can become a test-mode entry.
- R6: ras_n stays low for exactly max(ceil(60 ns), ceil(10 ns)) clock cycles (8). Between any two RAS-low pulses, ras_n stays high for at least ceil(40 ns) cycles (5).
- R7: ras_n or cas_n is low only in cycles where both pin_req and pin_grant are high.
- R8: After initialization, one refresh falls due every floor(PERIOD_US × CLK_MHZ / 2048) cycles. PERIOD_US is 32000 when LOW_POWER is 0, giving 1953 cycles, and 128000 when LOW_POWER is 1, giving 7812 cycles. With the grant always given, consecutive ref_done pulses are exactly that far apart.
- R9: Refreshes that fall due while the grant is withheld are counted, up to OWED_MAX (4). When the grant arrives, min(due, 4) refreshes run back to back, and then pin_req drops.
- R10: ref_done is a one-cycle pulse in the last precharge cycle of each refresh, with both strobes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_grant | input | 1 | Access controller hands the DRAM strobes to the sequencer |
| pin_req | output | 1 | Sequencer asks for the DRAM strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, held high during refresh |
| ref_done | output | 1 | Pulse on the last cycle of each completed refresh |
| init_done | output | 1 | High once the initialization burst has completed |

## Verification
The assertions check the strobe rules on every cycle: CAS ahead of RAS, the write strobe high around the RAS fall, the RAS-low width, strobe activity only under grant, the cap on owed refreshes, the one-cycle done pulse, silence during the pause, and the flag that stays set. Only the bench scenarios can show the timing of whole sequences. These are the exact length of the pause and of the initialization burst, the spacing between refreshes in both period modes, and the number of refreshes released after grant holds of different lengths. Some of those holds push the owed count past its cap.

// File: rtl/dref_pkg.sv
package dref_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_CSETUP,
    S_RASLO,
    S_PRECH
  } cbr_state_t;

  typedef enum logic [1:0] {
    P_PAUSE,
    P_INIT,
    P_RUN
  } phase_t;

  // whole clock cycles covering a time in ns, never below one
  function automatic int cyc_ceil(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // refresh spacing rounded down so the period is never exceeded
  function automatic int refresh_spacing(input int period_us, input int mhz, input int rows);
    return (period_us * mhz) / rows;
  endfunction

  function automatic int pause_cycles(input int us, input int mhz);
    return us * mhz;
  endfunction

  // saturating owed-refresh update
  function automatic int owed_step(input int cur, input bit inc, input bit dec, input int lim);
    int n;
    n = cur + (inc ? 1 : 0) - (dec ? 1 : 0);
    if (n > lim) n = lim;
    if (n < 0) n = 0;
    return n;
  endfunction

endpackage

// File: rtl/dref_phase.sv
module dref_phase
  import dref_pkg::*;
#(
  parameter int PAUSE_CYC = 25000,
  parameter int INIT_N    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic done,
  output logic init_want,
  output logic init_done,
  output logic pause_active
);
  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam int IW = $clog2(INIT_N + 1);

  phase_t          phase;
  logic [PW-1:0]   pcnt;
  logic [IW-1:0]   issued;
  logic [IW-1:0]   completed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= P_PAUSE;
      pcnt      <= '0;
      issued    <= '0;
      completed <= '0;
    end else begin
      case (phase)
        P_PAUSE: begin
          if (pcnt == PW'(PAUSE_CYC - 1)) phase <= P_INIT;
          else                            pcnt  <= pcnt + 1'b1;
        end
        P_INIT: begin
          if (take) issued <= issued + 1'b1;
          if (done) begin
            completed <= completed + 1'b1;
            if (completed == IW'(INIT_N - 1)) phase <= P_RUN;
          end
        end
        default: phase <= P_RUN;
      endcase
    end
  end

  assign init_want    = (phase == P_INIT) && (issued != IW'(INIT_N));
  assign init_done    = (phase == P_RUN);
  assign pause_active = (phase == P_PAUSE);

endmodule

// File: rtl/dref_interval.sv
module dref_interval #(
  parameter int INT_CYC = 1953
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = $clog2(INT_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (!en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(INT_CYC - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/dref_owed.sv
module dref_owed
  import dref_pkg::*;
#(
  parameter int OWED_MAX = 4,
  parameter int OW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [OW-1:0] owed,
  output logic          pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owed <= '0;
    else        owed <= OW'(owed_step(int'(owed), inc, dec, OWED_MAX));
  end

  assign pending = (owed != '0);

endmodule

// File: rtl/dref_cbr_fsm.sv
module dref_cbr_fsm
  import dref_pkg::*;
#(
  parameter int CSR_CYC   = 2,
  parameter int RASLO_CYC = 8,
  parameter int RP_CYC    = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic pin_grant,
  output logic pin_req,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic take,
  output logic ref_done
);
  localparam int TMAX = max2(max2(CSR_CYC, RASLO_CYC), RP_CYC);
  localparam int TW   = $clog2(TMAX + 1);

  cbr_state_t    state;
  logic [TW-1:0] tmr;
  logic          csr_last, ras_last, rp_last;

  assign csr_last = (tmr == TW'(CSR_CYC - 1));
  assign ras_last = (tmr == TW'(RASLO_CYC - 1));
  assign rp_last  = (tmr == TW'(RP_CYC - 1));

  assign take     = (state == S_REQ) && pin_grant;
  assign ref_done = (state == S_PRECH) && rp_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      tmr   <= '0;
    end else begin
      case (state)
        S_IDLE:   if (want) state <= S_REQ;
        S_REQ:    if (pin_grant) begin state <= S_CSETUP; tmr <= '0; end
        S_CSETUP: begin
          if (csr_last) begin state <= S_RASLO; tmr <= '0; end
          else          tmr <= tmr + 1'b1;
        end
        S_RASLO: begin
          if (ras_last) begin state <= S_PRECH; tmr <= '0; end
          else          tmr <= tmr + 1'b1;
        end
        S_PRECH: begin
          if (rp_last) begin
            state <= want ? S_REQ : S_IDLE;
            tmr   <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign pin_req = (state != S_IDLE);
  assign ras_n   = (state != S_RASLO);
  assign cas_n   = !((state == S_CSETUP) || (state == S_RASLO));
  assign we_n    = 1'b1;

endmodule

// File: rtl/dref_seq.sv
module dref_seq
  import dref_pkg::*;
#(
  parameter int CLK_MHZ        = 125,
  parameter bit LOW_POWER      = 1'b0,
  parameter int PAUSE_US       = 200,
  parameter int INIT_REFRESHES = 8,
  parameter int ROWS           = 2048,
  parameter int T_CSR_NS       = 10,
  parameter int T_CHR_NS       = 10,
  parameter int T_RAS_NS       = 60,
  parameter int T_RP_NS        = 40,
  parameter int OWED_MAX       = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_grant,
  output logic pin_req,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic ref_done,
  output logic init_done
);
  localparam int PERIOD_US = LOW_POWER ? 128000 : 32000;
  localparam int INT_CYC   = refresh_spacing(PERIOD_US, CLK_MHZ, ROWS);
  localparam int PAUSE_CYC = pause_cycles(PAUSE_US, CLK_MHZ);
  localparam int CSR_CYC   = cyc_ceil(T_CSR_NS, CLK_MHZ);
  localparam int RASLO_CYC = max2(cyc_ceil(T_RAS_NS, CLK_MHZ), cyc_ceil(T_CHR_NS, CLK_MHZ));
  localparam int RP_CYC    = cyc_ceil(T_RP_NS, CLK_MHZ);
  localparam int OWED_W    = $clog2(OWED_MAX + 1);

  // internal events, named for the checker
  logic              init_want;
  logic              pause_active;
  logic              tick;
  logic              take;
  logic              owed_pending;
  logic              want;
  logic [OWED_W-1:0] owed;

  dref_phase #(
    .PAUSE_CYC (PAUSE_CYC),
    .INIT_N    (INIT_REFRESHES)
  ) u_phase (
    .clk          (clk),
    .rst_n        (rst_n),
    .take         (take),
    .done         (ref_done),
    .init_want    (init_want),
    .init_done    (init_done),
    .pause_active (pause_active)
  );

  dref_interval #(
    .INT_CYC (INT_CYC)
  ) u_interval (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (init_done),
    .tick  (tick)
  );

  dref_owed #(
    .OWED_MAX (OWED_MAX),
    .OW       (OWED_W)
  ) u_owed (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (tick),
    .dec     (take && init_done),
    .owed    (owed),
    .pending (owed_pending)
  );

  assign want = init_want || owed_pending;

  dref_cbr_fsm #(
    .CSR_CYC   (CSR_CYC),
    .RASLO_CYC (RASLO_CYC),
    .RP_CYC    (RP_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .want      (want),
    .pin_grant (pin_grant),
    .pin_req   (pin_req),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .take      (take),
    .ref_done  (ref_done)
  );

endmodule

// File: rtl/dref_seq_chk.sv
module dref_seq_chk #(
  parameter int OWED_MAX = 4,
  parameter int OW       = 3,
  parameter int RAS_CYC  = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pin_req,
  input logic          pin_grant,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic          ref_done,
  input logic          init_done,
  input logic          pause_active,
  input logic          tick,
  input logic [OW-1:0] owed
);
  logic [15:0] ras_lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ras_lo_cnt <= '0;
    else if (!ras_n) ras_lo_cnt <= ras_lo_cnt + 1'b1;
    else             ras_lo_cnt <= '0;
  end

  a_r2_quiet_pause: assert property (@(posedge clk) disable iff (!rst_n)
    pause_active |-> !pin_req);

  a_r3_init_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  a_r4_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

  a_r4_release_together: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> $rose(cas_n));

  a_r5_we_high_at_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (we_n && $past(we_n)));

  a_r6_ras_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (ras_lo_cnt == 16'(RAS_CYC)));

  a_r7_pins_granted: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> (pin_req && pin_grant));

  a_r8_tick_after_init: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> init_done);

  a_r9_owed_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(owed) <= OWED_MAX);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |=> !ref_done);

  a_r10_done_strobes_high: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |-> (ras_n && cas_n));

endmodule

bind dref_seq dref_seq_chk #(
  .OWED_MAX (OWED_MAX),
  .OW       (OWED_W),
  .RAS_CYC  (RASLO_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pin_req      (pin_req),
  .pin_grant    (pin_grant),
  .ras_n        (ras_n),
  .cas_n        (cas_n),
  .we_n         (we_n),
  .ref_done     (ref_done),
  .init_done    (init_done),
  .pause_active (pause_active),
  .tick         (tick),
  .owed         (owed)
);

// File: tb/tb_dref_seq.sv
`timescale 1ns/1ps
module tb_dref_seq;
  localparam int TCK      = 8;                      // 125 MHz
  localparam int PAUSE_N  = 200000 / TCK;
  localparam int INIT_N   = 8;
  localparam int CSR_N    = (10 + TCK - 1) / TCK;
  localparam int RAS_N    = (60 + TCK - 1) / TCK;
  localparam int RP_N     = (40 + TCK - 1) / TCK;
  localparam int SEQ_N    = 1 + CSR_N + RAS_N + RP_N;
  localparam int INT_STD  = (32000000 / 2048) / TCK;
  localparam int INT_LP   = (128000000 / 2048) / TCK;
  localparam int OWED_CAP = 4;

  // {held-off intervals, refreshes expected after grant}
  localparam int VEC [5][2] = '{'{0, 0}, '{1, 1}, '{2, 2}, '{4, 4}, '{6, 4}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold = 1'b0;
  logic pin_grant, pin_req, ras_n, cas_n, we_n, ref_done, init_done;
  logic g_lp, req_lp, ras_lp, cas_lp, we_lp, done_lp, init_lp;

  int nchk = 0;
  int nfail = 0;

  always #(TCK/2) clk = ~clk;

  dref_seq dut (
    .clk(clk), .rst_n(rst_n), .pin_grant(pin_grant), .pin_req(pin_req),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ref_done(ref_done), .init_done(init_done)
  );

  dref_seq #(.LOW_POWER(1'b1)) dut_lp (
    .clk(clk), .rst_n(rst_n), .pin_grant(g_lp), .pin_req(req_lp),
    .ras_n(ras_lp), .cas_n(cas_lp), .we_n(we_lp), .ref_done(done_lp), .init_done(init_lp)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_grant <= 1'b0;
      g_lp      <= 1'b0;
    end else begin
      pin_grant <= pin_req && !hold;
      g_lp      <= req_lp;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor on the standard instance
  int cyc, first_req, last_done, n_init, total_done;
  int cas_lo, ras_lo, ras_hi;
  bit prev_ras, seen_rise, init_seen;
  // monitor on the low-power instance
  int lp_last, lp_span;

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; first_req = -1; last_done = -1; n_init = 0; total_done = 0;
      cas_lo = 0; ras_lo = 0; ras_hi = 0; prev_ras = 1'b1; seen_rise = 1'b0;
      init_seen = 1'b0; lp_last = -1; lp_span = 0;
    end else begin
      cyc++;
      if (pin_req && first_req < 0) first_req = cyc;
      if (ref_done) begin
        check(ras_hi == RP_N - 1 && ras_n && cas_n, "R10 done on last precharge cycle", ras_hi, RP_N - 1);
        if (!init_done && last_done >= 0)
          check(cyc - last_done == SEQ_N, "R3 init burst spacing", cyc - last_done, SEQ_N);
        if (!init_done) n_init++;
        last_done = cyc;
        total_done++;
      end
      if (init_done && !init_seen) begin
        init_seen = 1'b1;
        check(n_init == INIT_N && last_done == cyc - 1, "R3 init_done after eighth refresh", n_init, INIT_N);
      end
      if (prev_ras && !ras_n) begin
        check(cas_lo == CSR_N, "R4 CAS lead before RAS", cas_lo, CSR_N);
        check(we_n == 1'b1, "R5 we_n high at RAS fall", int'(we_n), 1);
        if (seen_rise) check(ras_hi >= RP_N, "R6 precharge width", ras_hi, RP_N);
      end
      if (!prev_ras && ras_n) begin
        check(ras_lo == RAS_N, "R6 RAS low width", ras_lo, RAS_N);
        check(cas_n == 1'b1, "R4 CAS rises with RAS", int'(cas_n), 1);
        seen_rise = 1'b1;
      end
      if (!ras_n || !cas_n)
        check(pin_grant && pin_req, "R7 strobes only under grant", int'(pin_grant), 1);
      cas_lo   = cas_n ? 0 : cas_lo + 1;
      ras_lo   = ras_n ? 0 : ras_lo + 1;
      ras_hi   = ras_n ? ras_hi + 1 : 0;
      prev_ras = ras_n;
      if (done_lp && init_lp) begin
        if (lp_last >= 0 && lp_span == 0) lp_span = cyc - lp_last;
        lp_last = cyc;
      end
    end
  end

  task automatic next_done();
    @(negedge clk);
    while (!ref_done) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int t0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(!pin_req && ras_n && cas_n && we_n, "R1 strobes idle in reset", int'(pin_req), 0);
    check(!init_done && !ref_done && !req_lp, "R1 flags clear in reset", int'(init_done), 0);
    rst_n = 1'b1;

    while (!init_done) @(negedge clk);
    check(first_req >= PAUSE_N && first_req <= PAUSE_N + 2, "R2 power-up pause", first_req, PAUSE_N + 1);

    // R8 steady spacing with the grant always given
    next_done();
    t0 = cyc;
    next_done();
    check(cyc - t0 == INT_STD, "R8 standard refresh spacing", cyc - t0, INT_STD);

    // R9 grant held off for a number of intervals
    for (int i = 0; i < 5; i++) begin
      int k, exp, base, tgt;
      k = VEC[i][0];
      exp = VEC[i][1];
      next_done();
      hold = 1'b1;
      tgt = cyc + k * INT_STD + INT_STD / 2;
      while (cyc < tgt) @(negedge clk);
      base = total_done;
      hold = 1'b0;
      repeat (300) @(negedge clk);
      check(total_done - base == exp, "R9 owed refreshes released", total_done - base, exp);
      check(!pin_req, "R9 request drops after owed burst", int'(pin_req), 0);
    end
    check(OWED_CAP == VEC[4][1], "R9 cap value", VEC[4][1], OWED_CAP);

    // R8 low-power spacing
    while (lp_span == 0) @(negedge clk);
    check(lp_span == INT_LP, "R8 low-power refresh spacing", lp_span, INT_LP);

    // R1 reset during operation
    while (pin_req || !ras_n) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!pin_req && ras_n && cas_n && we_n && !init_done && !ref_done, "R1 reset mid-run", int'(init_done), 0);

    summary();
    $finish;
  end

endmodule